// File: doc/BRIEF.md
# Bus-Invert Data Encoder

This block sits between a memory core and the pads of a 16-bit bus that carries both addresses and data. On the read side it cuts pad switching. Each new word is compared with the value that was last driven onto the bus. When more than half of the lines would change state, the complement of the word is driven instead, and a separate invert flag goes high beside it. The receiver uses that flag to restore the true value. On the write side the same flag comes from the host. When it is high, the block complements the incoming word before passing it inward.

Two configuration inputs control the encoding. One enables it. The other selects the synchronous burst read mode. Reads are encoded only for burst reads of the array. A single drive-enable output controls the tri-state of both the bus and the flag pin. During an address phase no inversion is applied in either direction. The history register always holds the word that was last driven on the bus. The first word of every burst is sent unchanged and becomes the new history.

Top module: `bus_invert_codec`

## Requirements
- R1: Where read inversion is allowed, let N be the number of bit positions in which the new word differs from the history register. The word is sent complemented when N is 9 or more. It is sent unchanged when N is 8 or less, so exactly 8 differing bits is not inverted.
- R2: `binv_out` is 1 in the same cycle as a complemented word on `bus_out`. It is 0 whenever `bus_out` equals `rd_word`.
- R3: Read inversion can only happen when `cfg_inv_en`=1, `cfg_burst`=1 and `rd_array`=1. If any of the three is 0, `bus_out` equals `rd_word`.
- R4: When `cfg_inv_en`=1, `binv_in`=1 and `addr_phase`=0, `wr_word` is the bitwise complement of `bus_in`. In every other case `wr_word` equals `bus_in`.
- R5: While `addr_phase`=1, `binv_in` is ignored. `wr_word` equals `bus_in`, `bus_out` equals `rd_word`, `binv_out` is 0, and the history register is not updated.
- R6: `drive_oe`, which controls the tri-state of the bus and the flag, is 0 when `chip_sel`=0, when `out_en`=0, or when `rst_n`=0.
- R7: While `rst_n`=0 nothing is inverted in either direction, and the history register is cleared to 0. As a result, the first non-first word after reset is compared against 0x0000.
- R8: A word is driven when `rd_valid`=1, `drive_oe`=1 and `addr_phase`=0. At the next clock edge the history register takes the value of `bus_out` for that word. A word with `rd_first`=1 is never inverted.
- R9: With `cfg_inv_en`=0, reads pass through unchanged with `binv_out`=0, and writes pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_inv_en | input | 1 | Configuration bit: bus inversion enabled |
| cfg_burst | input | 1 | Configuration bit: synchronous burst read mode |
| chip_sel | input | 1 | Device selected |
| out_en | input | 1 | Output enable from host |
| addr_phase | input | 1 | Bus currently carries an address |
| rd_valid | input | 1 | A read word is presented for driving this cycle |
| rd_first | input | 1 | Word is the first of a burst |
| rd_array | input | 1 | Word comes from the memory array |
| rd_word | input | 16 | True read word from the core |
| bus_out | output | 16 | Word to drive on the pads |
| binv_out | output | 1 | Invert flag driven beside `bus_out` |
| drive_oe | output | 1 | Tri-state enable for bus and flag pads |
| bus_in | input | 16 | Word received from the pads |
| binv_in | input | 1 | Invert flag received from the host |
| wr_word | output | 16 | Restored write word toward the core |

## Verification
The hardest cases to reach are the boundary between exactly 8 and exactly 9 differing bits, and a history that was itself written complemented. Uniform random words almost never land on those counts. The stimulus therefore builds many read words as the bench's model of the history XOR a mask with a chosen number of set bits. It also runs directed steps that hit 8 and 9 right after a complemented word, after a mid-run reset, and on a burst's first word.

// File: rtl/bi_pkg.sv
package bi_pkg;
  localparam int unsigned MAXW = 64;

  typedef enum logic [1:0] {
    DRV_IDLE = 2'd0,
    DRV_PASS = 2'd1,
    DRV_INV  = 2'd2
  } drv_kind_e;

  // Number of positions in which two words differ.
  function automatic int unsigned diff_bits(input logic [MAXW-1:0] a,
                                            input logic [MAXW-1:0] b);
    int unsigned n;
    logic [MAXW-1:0] x;
    x = a ^ b;
    n = 0;
    for (int i = 0; i < MAXW; i++) n += int'(x[i]);
    return n;
  endfunction
endpackage

// File: rtl/bi_hist.sv
module bi_hist #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  p_hist_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));
  p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/bi_enc.sv
module bi_enc
  import bi_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned THRESH = W / 2
) (
  input  logic         drive_now,
  input  logic         allow_inv,
  input  logic [W-1:0] rd_word,
  input  logic [W-1:0] hist,
  output logic [W-1:0] enc_word,
  output logic         enc_flag,
  output drv_kind_e    kind
);
  logic [MAXW-1:0] wide_rd, wide_hist;
  int unsigned     flips;
  logic            over;

  always_comb begin
    wide_rd   = '0;
    wide_hist = '0;
    wide_rd[W-1:0]   = rd_word;
    wide_hist[W-1:0] = hist;
    flips = diff_bits(wide_rd, wide_hist);
    over  = flips > THRESH;
  end

  always_comb begin
    if (!drive_now)          kind = DRV_IDLE;
    else if (allow_inv && over) kind = DRV_INV;
    else                     kind = DRV_PASS;
    enc_flag = (kind == DRV_INV);
    enc_word = enc_flag ? ~rd_word : rd_word;
  end

  always_comb begin
    if (enc_flag) a_flag_word_r2: assert (enc_word == ~rd_word);
    if (!allow_inv) a_no_inv_r3: assert (!enc_flag);
  end
endmodule

// File: rtl/bi_dec.sv
module bi_dec #(
  parameter int unsigned W = 16
) (
  input  logic         flip,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] wr_word
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign wr_word[i] = bus_in[i] ^ flip;
  end
endmodule

// File: rtl/bus_invert_codec.sv
module bus_invert_codec
  import bi_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_inv_en,
  input  logic         cfg_burst,
  input  logic         chip_sel,
  input  logic         out_en,
  input  logic         addr_phase,
  input  logic         rd_valid,
  input  logic         rd_first,
  input  logic         rd_array,
  input  logic [W-1:0] rd_word,
  output logic [W-1:0] bus_out,
  output logic         binv_out,
  output logic         drive_oe,
  input  logic [W-1:0] bus_in,
  input  logic         binv_in,
  output logic [W-1:0] wr_word
);
  localparam int unsigned HALF = W / 2;

  logic         drive_now;
  logic         rd_mode_ok;
  logic         allow_inv;
  logic         in_flip;
  logic [W-1:0] hist_q;
  drv_kind_e    kind;

  assign drive_oe   = rst_n & chip_sel & out_en;
  assign drive_now  = rd_valid & drive_oe & ~addr_phase;
  assign rd_mode_ok = rst_n & cfg_inv_en & cfg_burst & rd_array;
  assign allow_inv  = rd_mode_ok & ~rd_first;
  assign in_flip    = rst_n & cfg_inv_en & binv_in & ~addr_phase;

  bi_hist #(.W(W)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (drive_now),
    .d     (bus_out),
    .q     (hist_q)
  );

  bi_enc #(.W(W), .THRESH(HALF)) u_enc (
    .drive_now (drive_now),
    .allow_inv (allow_inv),
    .rd_word   (rd_word),
    .hist      (hist_q),
    .enc_word  (bus_out),
    .enc_flag  (binv_out),
    .kind      (kind)
  );

  bi_dec #(.W(W)) u_dec (
    .flip    (in_flip),
    .bus_in  (bus_in),
    .wr_word (wr_word)
  );

  p_few_toggles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_now && allow_inv) |-> ($countones(bus_out ^ hist_q) <= HALF));
  p_flag_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    binv_out |-> (bus_out == ~rd_word) && kind == DRV_INV);
  p_addr_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> !binv_out && wr_word == bus_in && bus_out == rd_word);
  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel || !out_en) |-> !drive_oe);
  p_off_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_inv_en |-> !binv_out && wr_word == bus_in);
  p_first_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_now && rd_first) |-> bus_out == rd_word);
endmodule

// File: tb/tb_bus_invert_codec.sv
`timescale 1ns/1ps
module tb_bus_invert_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_inv_en = 0, cfg_burst = 0, chip_sel = 0, out_en = 0;
  logic        addr_phase = 0, rd_valid = 0, rd_first = 0, rd_array = 0;
  logic [15:0] rd_word = '0, bus_in = '0;
  logic        binv_in = 0;
  logic [15:0] bus_out, wr_word;
  logic        binv_out, drive_oe;

  int unsigned n_chk = 0, n_bad = 0;
  logic [15:0] m_hist = '0;

  always #2 clk = ~clk;

  bus_invert_codec dut (
    .clk(clk), .rst_n(rst_n), .cfg_inv_en(cfg_inv_en), .cfg_burst(cfg_burst),
    .chip_sel(chip_sel), .out_en(out_en), .addr_phase(addr_phase),
    .rd_valid(rd_valid), .rd_first(rd_first), .rd_array(rd_array),
    .rd_word(rd_word), .bus_out(bus_out), .binv_out(binv_out),
    .drive_oe(drive_oe), .bus_in(bus_in), .binv_in(binv_in), .wr_word(wr_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, compare before the rising edge.
  task automatic step(input string tag, input logic rst, input logic en,
                      input logic bm, input logic cs, input logic oe,
                      input logic ad, input logic vl, input logic fi,
                      input logic ar, input logic [15:0] rw,
                      input logic [15:0] bi, input logic bv);
    logic drv, dn, inv, fl;
    logic [15:0] e_bus, e_wr;
    @(negedge clk);
    rst_n = rst; cfg_inv_en = en; cfg_burst = bm; chip_sel = cs; out_en = oe;
    addr_phase = ad; rd_valid = vl; rd_first = fi; rd_array = ar;
    rd_word = rw; bus_in = bi; binv_in = bv;
    #1;
    drv   = rst & cs & oe;
    dn    = vl & drv & ~ad;
    inv   = dn & rst & en & bm & ar & ~fi & ($countones(rw ^ m_hist) > 8);
    e_bus = inv ? ~rw : rw;
    fl    = rst & en & bv & ~ad;
    e_wr  = fl ? ~bi : bi;
    chk({tag, " bus_out"},  {16'd0, bus_out},  {16'd0, e_bus});
    chk({tag, " binv_out"}, {31'd0, binv_out}, {31'd0, inv});
    chk({tag, " drive_oe"}, {31'd0, drive_oe}, {31'd0, drv});
    chk({tag, " wr_word"},  {16'd0, wr_word},  {16'd0, e_wr});
    @(posedge clk);
    if (!rst)    m_hist = '0;
    else if (dn) m_hist = e_bus;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] mask, w;
    int unsigned k;
    void'($urandom(32'd17));
    // R7 R6: in reset, no drive and no inversion either way
    step("R7 reset", 0, 1,1,1,1, 0, 1,0,1, 16'hFFFF, 16'h1234, 1);
    step("R6 reset oe", 0, 1,1,1,1, 0, 1,0,1, 16'h00FF, 16'hABCD, 1);
    // R8 first word plain, then R1 R2 nine-bit case
    step("R8 first", 1, 1,1,1,1, 0, 1,1,1, 16'h0000, 16'h0, 0);
    step("R1 R2 nine", 1, 1,1,1,1, 0, 1,0,1, 16'h01FF, 16'h0, 0);
    step("R1 eight", 1, 1,1,1,1, 0, 1,0,1, m_hist ^ 16'h00FF, 16'h0, 0);
    step("R1 nine again", 1, 1,1,1,1, 0, 1,0,1, m_hist ^ 16'hFF80, 16'h0, 0);
    step("R8 first big", 1, 1,1,1,1, 0, 1,1,1, ~m_hist, 16'h0, 0);
    // R9 R3 pass-through cases
    step("R9 disabled", 1, 0,1,1,1, 0, 1,0,1, ~m_hist, 16'h5A5A, 1);
    step("R3 async mode", 1, 1,0,1,1, 0, 1,0,1, ~m_hist, 16'h0, 0);
    step("R3 non-array", 1, 1,1,1,1, 0, 1,0,0, ~m_hist, 16'h0, 0);
    // R5 address phase
    step("R5 addr", 1, 1,1,1,1, 1, 1,0,1, ~m_hist, 16'hC3C3, 1);
    step("R5 after addr", 1, 1,1,1,1, 0, 1,0,1, m_hist ^ 16'h03FF, 16'h0, 0);
    // R4 input decode
    step("R4 in flip", 1, 1,0,1,0, 0, 0,0,0, 16'h0, 16'h1F2E, 1);
    step("R4 in no flag", 1, 1,0,1,0, 0, 0,0,0, 16'h0, 16'h1F2E, 0);
    // R6 deselect and output disable
    step("R6 deselect", 1, 1,1,0,1, 0, 1,0,1, 16'hFFFF, 16'h0, 0);
    step("R6 out off", 1, 1,1,1,0, 0, 1,0,1, 16'hFFFF, 16'h0, 0);
    // R7 mid-run reset clears history
    step("R7 reset mid", 0, 1,1,1,1, 0, 1,0,1, 16'hAAAA, 16'h0, 0);
    step("R7 vs zero", 1, 1,1,1,1, 0, 1,0,1, 16'h03FF, 16'h0, 0);
    step("R7 eight vs hist", 1, 1,1,1,1, 0, 1,0,1, m_hist ^ 16'hF00F, 16'h0, 0);
    // Random mix: R1 R2 R3 R4 R5 R8 R9
    for (int i = 0; i < 3000; i++) begin
      k = $urandom_range(0, 16);
      mask = 16'h0;
      for (int b = 0; b < 16; b++) begin
        if (mask == 16'h0 || $countones(mask) < k) mask[$urandom_range(0, 15)] = 1'b1;
      end
      if (k == 0) mask = 16'h0;
      w = ($urandom_range(0, 3) == 0) ? 16'($urandom) : (m_hist ^ mask);
      step("R1 R8 random", 1,
           $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
           $urandom_range(0, 15) != 0, $urandom_range(0, 15) != 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 7) != 0,
           $urandom_range(0, 11) == 0, $urandom_range(0, 7) != 0,
           w, 16'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule